// File: doc/BRIEF.md
# DDR Mode Register Initialisation Sequencer

This block sits on the controller side of a DDR-style memory interface. It programs the device's two mode registers in the order the device requires. A single start pulse latches the requested settings: burst length, burst ordering, CAS latency, DLL on/off and output drive strength. The block then issues load-mode-register commands on a command bus made of a command field, a bank-address field and an address field.

Between commands it drives NOP for a programmable gap. The first write goes to the extended register. If the DLL is requested on, a base-register write with the DLL-reset bit follows. The last write puts the base register in normal operating mode.

A request that carries a reserved burst-length or latency code is refused. No command goes out for it. The busy flag lets the surrounding controller hold off other traffic, and a one-cycle done pulse marks the end of the sequence.

Top module: `mrs_init_seq`

## Requirements
- R1: After reset, cmd is NOP (3'b111), ba and addr are zero, and busy, done and reject are low.
- R2: The cycle after an accepted start, cmd is load-mode (3'b000) with ba = 2'b01 (extended register). In that write, addr[0] is 1 when the DLL is to be disabled, addr[1] is the reduced-drive flag, and all other address bits are zero.
- R3: When dll_on was set, the second command is load-mode with ba = 2'b00, addr[8] = 1, addr[7] = 0, addr[6:0] = the mode field, and every bit above 8 zero.
- R4: The final command is load-mode with ba = 2'b00, every address bit from 7 upward zero, and addr[6:0] = the mode field. The mode field is laid out as follows. Bits 2:0 hold the burst length (1 = two, 2 = four, 3 = eight). Bit 3 holds the ordering (1 = interleaved). Bits 6:4 hold the latency (3'b010 = 2, 3'b110 = 2.5, 3'b011 = 3). A base-register write never carries an operating-mode value other than all-zero or only bit 8 set.
- R5: Every load-mode command is followed by exactly gap+1 NOP cycles, with ba and addr zero, before the next command or the done cycle.
- R6: When dll_on was clear, the DLL-reset write is skipped, so only the extended write and the normal-mode write are issued.
- R7: busy is high from the first command through the last NOP cycle. done is then high for exactly one cycle with busy low, and the block returns to idle.
- R8: A start while busy or during the done cycle is ignored. A start present in the idle cycle after done is accepted.
- R9: A start with a burst-length code outside 1..3, or a latency code other than 3'b010, 3'b011 or 3'b110, issues no command, keeps busy low, and pulses reject for one cycle in the next cycle.
- R10: The settings are captured when start is accepted. Input changes during a sequence do not alter its commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to run the sequence |
| burst_len | input | 3 | Burst length code |
| burst_ilv | input | 1 | 1 selects interleaved ordering |
| cas_code | input | 3 | CAS latency code |
| dll_on | input | 1 | 1 enables the DLL and its reset write |
| drive_weak | input | 1 | 1 selects reduced output drive |
| gap | input | GAP_W | NOP cycles between commands, minus one |
| cmd | output | 3 | Command {ras_n, cas_n, we_n} |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address / register value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| reject | output | 1 | One-cycle pulse for a refused request |

## Verification
Several properties are checked on every cycle:
- a load-mode command only occurs while busy and is always followed by a NOP;
- the first busy cycle is an extended-register write whose upper address bits are clear;
- base-register operating-mode bits are always all-zero or only bit 8;
- done is a lone cycle with busy low;
- reject only follows a start and never coincides with a command.

Other behaviour is shown only by the bench's cycle-exact model across its scenarios: the exact gap length, the skipping of the DLL-reset write, the latching of settings, and the ignoring of start during busy and done.

// File: rtl/mrs_init_seq.sv
module mrs_init_seq #(
  parameter int ADDR_W = 12,
  parameter int GAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        burst_len,
  input  logic              burst_ilv,
  input  logic [2:0]        cas_code,
  input  logic              dll_on,
  input  logic              drive_weak,
  input  logic [GAP_W-1:0]  gap,
  output logic [2:0]        cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done,
  output logic              reject
);
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_LMR = 3'b000;
  localparam int OPW = ADDR_W - 7;

  typedef enum logic [2:0] {S_IDLE, S_EMR, S_WAIT, S_DLLR, S_NORM, S_DONE} st_t;

  st_t             state, after;
  logic [GAP_W-1:0] cnt, gap_q;
  logic [6:0]      mode_q;
  logic            dll_q, drv_q, rej_q;
  logic            req_ok;

  assign req_ok = (burst_len inside {3'd1, 3'd2, 3'd3}) &&
                  (cas_code inside {3'b010, 3'b011, 3'b110});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      after  <= S_IDLE;
      cnt    <= '0;
      gap_q  <= '0;
      mode_q <= '0;
      dll_q  <= 1'b0;
      drv_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      rej_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (req_ok) begin
            state  <= S_EMR;
            mode_q <= {cas_code, burst_ilv, burst_len};
            dll_q  <= dll_on;
            drv_q  <= drive_weak;
            gap_q  <= gap;
          end else begin
            rej_q <= 1'b1;
          end
        end
        S_EMR: begin
          state <= S_WAIT;
          cnt   <= gap_q;
          after <= dll_q ? S_DLLR : S_NORM;
        end
        S_DLLR: begin
          state <= S_WAIT;
          cnt   <= gap_q;
          after <= S_NORM;
        end
        S_NORM: begin
          state <= S_WAIT;
          cnt   <= gap_q;
          after <= S_DONE;
        end
        S_WAIT: if (cnt == '0) state <= after; else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd  = CMD_NOP;
    ba   = 2'b00;
    addr = '0;
    case (state)
      S_EMR: begin
        cmd       = CMD_LMR;
        ba        = 2'b01;
        addr[1:0] = {drv_q, ~dll_q};
      end
      S_DLLR: begin
        cmd       = CMD_LMR;
        addr[6:0] = mode_q;
        addr[8]   = 1'b1;
      end
      S_NORM: begin
        cmd       = CMD_LMR;
        addr[6:0] = mode_q;
      end
      default: ;
    endcase
  end

  assign busy   = !(state == S_IDLE || state == S_DONE);
  assign done   = (state == S_DONE);
  assign reject = rej_q;

  p_lmr_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_LMR |-> busy);
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cmd == CMD_NOP));
  p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_opmode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR && ba == 2'b00) |->
      (addr[ADDR_W-1:7] == '0 || addr[ADDR_W-1:7] == OPW'(2)));
  p_ext_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd == CMD_LMR && ba == 2'b01));
  p_ext_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR && ba == 2'b01) |-> addr[ADDR_W-1:2] == '0);
  p_nop_after_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_LMR |=> cmd == CMD_NOP);
  p_reject_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!busy && cmd == CMD_NOP && $past(start)));
endmodule

// File: tb/sim_mrs_init_seq.sv
module sim_mrs_init_seq;
  localparam int AW = 12;
  localparam int GW = 4;
  localparam logic [2:0] NOP = 3'b111;
  localparam logic [2:0] LMR = 3'b000;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]    burst_len = 3'd2, cas_code = 3'b010;
  logic          burst_ilv = 1'b0, dll_on = 1'b1, drive_weak = 1'b0;
  logic [GW-1:0] gap = '0;
  logic [2:0]    cmd;
  logic [1:0]    ba;
  logic [AW-1:0] addr;
  logic          busy, done, reject;

  always #10 clk = ~clk;

  mrs_init_seq #(.ADDR_W(AW), .GAP_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len),
    .burst_ilv(burst_ilv), .cas_code(cas_code), .dll_on(dll_on),
    .drive_weak(drive_weak), .gap(gap), .cmd(cmd), .ba(ba), .addr(addr),
    .busy(busy), .done(done), .reject(reject));

  typedef struct {
    logic [2:0]    c;
    logic [1:0]    b;
    logic [AW-1:0] a;
    logic          bz, dn, rj, idle;
    string         tag;
  } exp_t;

  exp_t  q[$];
  int    checks = 0, fails = 0;
  string note = "";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s%s %s: actual %0h expected %0h", tag, note, what, act, expv);
    end
  endtask

  function automatic exp_t mk(logic [2:0] c, logic [1:0] b, int a,
                              logic bz, logic dn, logic rj, logic idle, string tag);
    exp_t e;
    e.c = c; e.b = b; e.a = AW'(a); e.bz = bz; e.dn = dn; e.rj = rj;
    e.idle = idle; e.tag = tag;
    return e;
  endfunction

  task automatic push_gap(int g);
    for (int i = 0; i <= g; i++) q.push_back(mk(NOP, 2'b00, 0, 1, 0, 0, 0, "R5"));
  endtask

  always @(negedge clk) begin
    exp_t e;
    int   mode;
    bit   ok;
    if (!rst_n) begin
      q.delete();
    end else begin
      if (q.size() > 0) e = q.pop_front();
      else e = mk(NOP, 2'b00, 0, 0, 0, 0, 1, "R1");
      chk(e.tag, "cmd", 32'(cmd), 32'(e.c));
      chk(e.tag, "ba", 32'(ba), 32'(e.b));
      chk(e.tag, "addr", 32'(addr), 32'(e.a));
      chk(e.tag, "busy", 32'(busy), 32'(e.bz));
      chk(e.tag, "done", 32'(done), 32'(e.dn));
      chk(e.tag, "reject", 32'(reject), 32'(e.rj));
      if (e.idle && start) begin
        ok = (burst_len >= 3'd1 && burst_len <= 3'd3) &&
             (cas_code == 3'd2 || cas_code == 3'd3 || cas_code == 3'd6);
        if (!ok) begin
          q.push_back(mk(NOP, 2'b00, 0, 0, 0, 1, 1, "R9"));
        end else begin
          mode = int'(cas_code) * 16 + int'(burst_ilv) * 8 + int'(burst_len);
          q.push_back(mk(LMR, 2'b01, int'(drive_weak) * 2 + (dll_on ? 0 : 1),
                         1, 0, 0, 0, "R2"));
          push_gap(int'(gap));
          if (dll_on) begin
            q.push_back(mk(LMR, 2'b00, 256 + mode, 1, 0, 0, 0, "R3"));
            push_gap(int'(gap));
            q.push_back(mk(LMR, 2'b00, mode, 1, 0, 0, 0, "R4"));
          end else begin
            q.push_back(mk(LMR, 2'b00, mode, 1, 0, 0, 0, "R6"));
          end
          push_gap(int'(gap));
          q.push_back(mk(NOP, 2'b00, 0, 0, 1, 0, 0, "R7"));
        end
      end
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic req(logic [2:0] bl, logic ilv, logic [2:0] cl, logic dl,
                     logic wk, int g);
    @(posedge clk); #2;
    burst_len = bl; burst_ilv = ilv; cas_code = cl; dll_on = dl;
    drive_weak = wk; gap = GW'(g); start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset cmd", 32'(cmd), 32'(NOP));
    chk("R1", "reset busy", 32'(busy), 0);
    chk("R1", "reset addr", 32'(addr), 0);

    req(3'd2, 1'b0, 3'b010, 1'b1, 1'b0, 2);
    wait_done();
    req(3'd3, 1'b1, 3'b110, 1'b0, 1'b1, 0);
    wait_done();

    note = " R8 R10";
    req(3'd1, 1'b0, 3'b011, 1'b1, 1'b0, 1);
    @(posedge clk); #2;
    burst_len = 3'd3; cas_code = 3'b110; dll_on = 1'b0; gap = 4'd5; start = 1'b1;
    do @(negedge clk); while (!done);
    @(negedge clk);
    @(posedge clk); #2 start = 1'b0;
    wait_done();

    note = " R9";
    req(3'd0, 1'b0, 3'b010, 1'b1, 1'b0, 1);
    repeat (2) @(posedge clk);
    req(3'd4, 1'b0, 3'b010, 1'b1, 1'b0, 1);
    repeat (2) @(posedge clk);
    req(3'd2, 1'b0, 3'b001, 1'b1, 1'b0, 1);
    repeat (2) @(posedge clk);
    req(3'd2, 1'b1, 3'b111, 1'b0, 1'b1, 1);
    repeat (3) @(posedge clk);

    note = "";
    req(3'd3, 1'b0, 3'b011, 1'b1, 1'b1, 15);
    wait_done();
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule